// File: doc/BRIEF.md
# Windowed on-chip RAM decoder

This block is a small static RAM with its own address decoder, placed between a CPU bus (24-bit byte address, 16-bit data, byte and word transfers) and the request path toward the external bus. While the enable input is high, the block serves two fixed address windows from one internal array. The main window runs from a parameterised start (`RAM_BASE`, default 0xFFD000) up to 0xFFEFBF. The high window covers 0xFFFFC0 to 0xFFFFFF. Every internal transfer completes in a single cycle.

Accesses that miss both windows are handed to off-chip space by raising `ext_req` in the same cycle. So is every access made while the enable input is low. The range from 0xFFB000 up to `RAM_BASE` is reserved while the enable input is high: it has no storage, reads return zero, writes have no effect, and nothing is forwarded. The array stores the main window first. The 64 bytes of the high window form the last 32 words of the array.

Top module: `onchip_ram_window`

## Requirements
- R1: After reset, `ack`, `align_err` and `rdata` are all zero.
- R2: With `ram_en`=1, a request in the main window (`RAM_BASE`..0xFFEFBF, including both ends) keeps `ext_req` low and raises `ack` in the cycle after the request edge.
- R3: With `ram_en`=1, the high window 0xFFFFC0..0xFFFFFF is served internally. Its storage is separate from the main window's storage, and a write to one window leaves the other unchanged.
- R4: With `ram_en`=0, every request raises `ext_req` in the same cycle and does not raise `ack`. A write made in this state leaves the internal array unchanged.
- R5: With `ram_en`=1, a request outside both windows and outside the reserved range raises `ext_req` in the same cycle and does not raise `ack`. Examples are 0xFFEFC0, 0xFFFFBF and 0x001234.
- R6: Bytes are big-endian. An even byte address uses data bits 15:8 and an odd byte address uses bits 7:0, on both `wdata` and `rdata`. A byte read returns zero on the unused lane, and a byte write leaves the other byte of the word unchanged.
- R7: A word access (`word`=1) at an even address writes or returns all 16 bits. A read returns the last value written to that word.
- R8: A word request at an odd address inside a window raises `ack` and `align_err` for exactly one cycle, returns `rdata`=0 and leaves the array unchanged.
- R9: With `ram_en`=1, a request in the reserved range 0xFFB000..`RAM_BASE`-1 raises `ack` with `rdata`=0, keeps `ext_req` low and changes no stored data.
- R10: A completed write returns `rdata`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ram_en | input | 1 | RAM enable bit |
| req | input | 1 | Bus request, one cycle per transfer |
| addr | input | 24 | Byte address |
| we | input | 1 | 1 = write, 0 = read |
| word | input | 1 | 1 = word transfer, 0 = byte transfer |
| wdata | input | 16 | Write data, big-endian lanes |
| rdata | output | 16 | Read data, valid while `ack` is high |
| ack | output | 1 | Internal or reserved transfer complete |
| align_err | output | 1 | Odd-address word access, one-cycle pulse |
| ext_req | output | 1 | Combinational forward request toward off-chip space |

## Verification
`ext_req` is combinational, so the bench checks it a short delay after it drives a request and before the clock edge that samples that request. `ack`, `rdata` and `align_err` are registered, so the bench samples them at the falling edge after that clock edge. One cycle after an idle cycle, the bench checks that `align_err` is low again. Claims that a write was ignored are checked by reading back the affected words through the normal read path.

// File: rtl/onchip_ram_window.sv
module onchip_ram_window #(
  parameter logic [23:0] RAM_BASE = 24'hFFD000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ram_en,
  input  logic        req,
  input  logic [23:0] addr,
  input  logic        we,
  input  logic        word,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  output logic        ack,
  output logic        align_err,
  output logic        ext_req
);
  localparam logic [23:0] MAIN_END = 24'hFFEFC0;
  localparam logic [23:0] HI_LO    = 24'hFFFFC0;
  localparam logic [23:0] RSV_LO   = 24'hFFB000;
  localparam int MAIN_WORDS = int'((MAIN_END - RAM_BASE) >> 1);
  localparam int WORDS      = MAIN_WORDS + 32;
  localparam int IW         = $clog2(WORDS);
  localparam logic [IW-1:0] HI_BASE = IW'(MAIN_WORDS);

  logic [15:0] mem [WORDS];

  logic in_main, in_hi, in_rsv, in_win, misal, hit, wr_hi, wr_lo;
  logic [IW-1:0] idx;
  logic [15:0] rword;

  assign in_main = addr >= RAM_BASE && addr < MAIN_END;
  assign in_hi   = addr >= HI_LO;
  assign in_rsv  = addr >= RSV_LO && addr < RAM_BASE;
  assign in_win  = in_main || in_hi;
  assign misal   = word && addr[0];
  assign hit     = req && ram_en && in_win && !misal;
  assign ext_req = req && !(ram_en && (in_win || in_rsv));
  assign wr_hi   = hit && we && (word || !addr[0]);
  assign wr_lo   = hit && we && (word || addr[0]);

  assign idx   = in_hi ? HI_BASE + IW'(addr[5:1]) : IW'((addr - RAM_BASE) >> 1);
  assign rword = mem[idx];

  always_ff @(posedge clk) begin
    if (wr_hi) mem[idx][15:8] <= wdata[15:8];
    if (wr_lo) mem[idx][7:0]  <= wdata[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata     <= '0;
      ack       <= 1'b0;
      align_err <= 1'b0;
    end else begin
      ack       <= req && ram_en && (in_win || in_rsv);
      align_err <= req && ram_en && in_win && misal;
      if (hit && !we)
        rdata <= word    ? rword :
                 addr[0] ? {8'h00, rword[7:0]} : {rword[15:8], 8'h00};
      else
        rdata <= '0;
    end
  end

  p_int_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ext_req) |=> ack);
  p_off_forward_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ram_en) |-> ext_req);
  p_ext_no_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req && ext_req) |=> !ack);
  p_err_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> ($past(req) && $past(word) && $past(addr[0]) && ack && rdata == 16'h0));
  p_err_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (align_err && !$past(req)) |-> 1'b0);
  p_rsv_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req && ram_en && addr >= RSV_LO && addr < RAM_BASE) |=> (ack && rdata == 16'h0));
  p_wr_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req && we) |=> rdata == 16'h0);
endmodule

// File: tb/sim_onchip_ram_window.sv
module sim_onchip_ram_window;
  localparam int CLK_T = 10;

  logic clk = 0, rst_n = 0, ram_en = 0, req = 0, we = 0, word = 0;
  logic [23:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic ack, align_err, ext_req;
  int checks = 0, errors = 0;
  logic s_ack, s_err, s_ext;
  logic [15:0] s_rd;

  onchip_ram_window u0 (.clk(clk), .rst_n(rst_n), .ram_en(ram_en), .req(req),
    .addr(addr), .we(we), .word(word), .wdata(wdata), .rdata(rdata), .ack(ack),
    .align_err(align_err), .ext_req(ext_req));

  always #(CLK_T/2) clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic op(input logic en, input logic [23:0] a, input logic w,
                    input logic wd, input logic [15:0] d);
    @(negedge clk);
    ram_en = en; req = 1; addr = a; we = w; word = wd; wdata = d;
    #1 s_ext = ext_req;
    @(negedge clk);
    s_ack = ack; s_rd = rdata; s_err = align_err;
    req = 0; we = 0;
  endtask

  task automatic rd_word(input logic [23:0] a, input logic [15:0] exp, input string tag);
    op(1, a, 0, 1, 16'h0);
    chk(tag, {15'h0, s_ack}, 16'h1);
    chk(tag, s_rd, exp);
  endtask

  task automatic t_reset;
    chk("R1 ack", {15'h0, ack}, 16'h0);
    chk("R1 err", {15'h0, align_err}, 16'h0);
    chk("R1 rdata", rdata, 16'h0);
  endtask

  task automatic t_main;
    op(1, 24'hFFD000, 1, 1, 16'h1357);
    chk("R2 ext low", {15'h0, s_ext}, 16'h0);
    chk("R2 ack", {15'h0, s_ack}, 16'h1);
    chk("R10 write rdata", s_rd, 16'h0);
    op(1, 24'hFFEFBE, 1, 1, 16'h2468);
    chk("R2 end ext", {15'h0, s_ext}, 16'h0);
    rd_word(24'hFFD000, 16'h1357, "R7 base word");
    rd_word(24'hFFEFBE, 16'h2468, "R7 end word");
  endtask

  task automatic t_high;
    op(1, 24'hFFFFC0, 1, 1, 16'hCAFE);
    chk("R3 ext low", {15'h0, s_ext}, 16'h0);
    op(1, 24'hFFFFFE, 1, 1, 16'hBEEF);
    rd_word(24'hFFFFC0, 16'hCAFE, "R3 hi first");
    rd_word(24'hFFFFFE, 16'hBEEF, "R3 hi last");
    rd_word(24'hFFEFBE, 16'h2468, "R3 main untouched");
    op(1, 24'hFFEFBE, 1, 1, 16'h7777);
    rd_word(24'hFFFFC0, 16'hCAFE, "R3 hi untouched");
  endtask

  task automatic t_bytes;
    op(1, 24'hFFD010, 1, 1, 16'hA1B2);
    op(1, 24'hFFD010, 0, 0, 16'h0);
    chk("R6 even byte", s_rd, 16'hA100);
    op(1, 24'hFFD011, 0, 0, 16'h0);
    chk("R6 odd byte", s_rd, 16'h00B2);
    op(1, 24'hFFD011, 1, 0, 16'h99CC);
    rd_word(24'hFFD010, 16'hA1CC, "R6 odd write");
    op(1, 24'hFFD012, 1, 1, 16'h1234);
    op(1, 24'hFFD012, 1, 0, 16'h55EE);
    rd_word(24'hFFD012, 16'h5534, "R6 even write");
  endtask

  task automatic t_align;
    op(1, 24'hFFD020, 1, 1, 16'h0F0F);
    op(1, 24'hFFD021, 1, 1, 16'hFFFF);
    chk("R8 err", {15'h0, s_err}, 16'h1);
    chk("R8 ack", {15'h0, s_ack}, 16'h1);
    @(negedge clk);
    chk("R8 pulse", {15'h0, align_err}, 16'h0);
    op(1, 24'hFFD021, 0, 1, 16'h0);
    chk("R8 rd err", {15'h0, s_err}, 16'h1);
    chk("R8 rd zero", s_rd, 16'h0);
    rd_word(24'hFFD020, 16'h0F0F, "R8 unchanged");
  endtask

  task automatic t_rsv;
    op(1, 24'hFFB000, 1, 1, 16'hDEAD);
    chk("R9 ext", {15'h0, s_ext}, 16'h0);
    chk("R9 ack", {15'h0, s_ack}, 16'h1);
    op(1, 24'hFFB000, 0, 1, 16'h0);
    chk("R9 rd zero", s_rd, 16'h0);
    op(1, 24'hFFCFFE, 1, 1, 16'hDEAD);
    op(1, 24'hFFCFFE, 0, 1, 16'h0);
    chk("R9 top zero", s_rd, 16'h0);
    chk("R9 top ext", {15'h0, s_ext}, 16'h0);
    rd_word(24'hFFD000, 16'h1357, "R9 base kept");
  endtask

  task automatic t_off;
    op(0, 24'hFFD000, 1, 1, 16'h4444);
    chk("R4 ext", {15'h0, s_ext}, 16'h1);
    chk("R4 no ack", {15'h0, s_ack}, 16'h0);
    op(0, 24'hFFFFC0, 0, 1, 16'h0);
    chk("R4 hi ext", {15'h0, s_ext}, 16'h1);
    rd_word(24'hFFD000, 16'h1357, "R4 unchanged");
  endtask

  task automatic t_out;
    op(1, 24'hFFEFC0, 0, 1, 16'h0);
    chk("R5 gap ext", {15'h0, s_ext}, 16'h1);
    chk("R5 gap ack", {15'h0, s_ack}, 16'h0);
    op(1, 24'hFFFFBF, 0, 0, 16'h0);
    chk("R5 below hi", {15'h0, s_ext}, 16'h1);
    op(1, 24'h001234, 1, 1, 16'h1);
    chk("R5 low ext", {15'h0, s_ext}, 16'h1);
    chk("R5 low ack", {15'h0, s_ack}, 16'h0);
  endtask

  initial begin
    #(CLK_T * 20000);
    errors++;
    $display("FAIL watchdog actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_T * 3);
    t_reset();
    @(negedge clk) rst_n = 1;
    t_main();
    t_high();
    t_bytes();
    t_align();
    t_rsv();
    t_off();
    t_out();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule